// File: doc/BRIEF.md
# MESI Cache Tag and Coherence Directory

This block holds the tags and the per-line coherence state for a two-way set-associative cache of 16 sets, with 256-byte lines. A local agent presents one read or write request at a time on a byte address. The block looks the address up and decides on one of three outcomes:

- The request completes at once.
- The request needs a permission upgrade on the coherent bus.
- The request needs a fill, which may be preceded by a write-back of the line being replaced.

Each bus action is a request/acknowledge handshake that the surrounding system completes. When the handshake ends, the block reports hit or miss, the way used, and whether the replaced line had to be written back.

Other caches' bus traffic reaches the block as snoops. A snoop looks up its address in the same cycle and reports a hit. It also reports whether this cache must supply dirty data. The affected line is then downgraded to Shared or dropped to Invalid.

Each line's coherence state decides two things. It decides whether a write may proceed without bus traffic. It also decides whether evicting the line costs a write-back. Empty ways are always filled before a valid line is displaced. The data array itself lives elsewhere.

Top module: `mesi_dir`

## Requirements
- R1: The set index is address bits [11:8] and the tag is bits [31:12]. A line hits only when the indexed set holds its tag in a valid state.
- R2: Address bits [7:0] play no part in lookup. Every address driven on bus_addr_o has its low 8 bits at zero.
- R3: On a miss, the fill goes to an Invalid way of the set if one exists, taking way 0 when both ways are Invalid. This holds even when the LRU bit points elsewhere.
- R4: When both ways are valid, the fill replaces the way named by the set's LRU bit. Every hit and every fill marks the way it touched as most recently used.
- R5: A Modified victim is first written back with bus command 0 (write-back) at the victim's own address. Only after that handshake is acknowledged does the fill command start. The response then carries resp_wb_o=1.
- R6: An Exclusive or Shared victim is dropped with no write-back command, and the response carries resp_wb_o=0.
- R7: A write that hits an Exclusive or Modified line completes with no bus command and leaves the line Modified.
- R8: A write that hits a Shared line issues bus command 3 (invalidate) for that line. A write that misses issues command 2 (read-for-ownership). In both cases the line becomes Modified only at the acknowledge. A write to a Shared line reports resp_hit_o=1.
- R9: A read miss issues bus command 1 (read). The line is filled Exclusive when bus_shared_i is low at the acknowledge, and Shared when it is high.
- R10: An Invalid line never hits. After rst_ni is asserted, every line is Invalid, including a line whose stored tag happens to equal the requested one.
- R11: A snoop with snp_cmd_i=1 (read) that hits a Modified or Exclusive line moves it to Shared. snp_supply_o is high only when such a snoop hits a Modified line.
- R12: A snoop with snp_cmd_i=2 (read-for-ownership) or 3 (invalidate) that hits a valid line moves it to Invalid. snp_hit_o is high only for a valid snoop (snp_valid_i high, snp_cmd_i nonzero) that hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Local request present, taken when req_ready_o is high |
| req_write_i | input | 1 | Local request is a write |
| req_addr_i | input | 32 | Local request byte address |
| req_ready_o | output | 1 | Block idle and accepting a request |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_hit_o | output | 1 | Request hit a valid line |
| resp_way_o | output | 1 | Way hit or filled |
| resp_wb_o | output | 1 | Replaced line needed a write-back |
| bus_req_o | output | 1 | Bus action pending |
| bus_cmd_o | output | 2 | 0 write-back, 1 read, 2 read-for-ownership, 3 invalidate |
| bus_addr_o | output | 32 | Line-aligned address of the bus action |
| bus_ack_i | input | 1 | Bus action completed in this cycle |
| bus_shared_i | input | 1 | Another cache holds the line, sampled with a read acknowledge |
| snp_valid_i | input | 1 | Snoop present |
| snp_cmd_i | input | 2 | 0 none, 1 read, 2 read-for-ownership, 3 invalidate |
| snp_addr_i | input | 32 | Snoop byte address |
| snp_hit_o | output | 1 | Snoop hit a valid line |
| snp_supply_o | output | 1 | Snoop hit a Modified line on a read, so this cache supplies the data |

## Verification
The bench builds the block with its default values: 32-bit addresses, 16 sets and an 8-bit offset. With these values, the index, tag and offset positions named in the requirements are exactly the ones exercised.

Most of the activity is concentrated in set 0, which is walked through both ways. This brings within reach:

- Invalid-first filling.
- LRU victim choice after mixed hits and fills.
- Back-to-back write-backs of Modified victims.
- The silent drop of an Exclusive victim.

Further sets test the write-miss and snoop paths without disturbing set 0's LRU history. Every snooped transition is then confirmed by a later local access whose bus traffic depends on the state the snoop left behind.

// File: rtl/mesi_dir_pkg.sv
package mesi_dir_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    BUS_WB  = 2'd0,
    BUS_RD  = 2'd1,
    BUS_RFO = 2'd2,
    BUS_INV = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    SNP_NONE = 2'd0,
    SNP_RD   = 2'd1,
    SNP_RFO  = 2'd2,
    SNP_INV  = 2'd3
  } snp_cmd_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_WB   = 2'd1,
    FSM_FILL = 2'd2
  } fsm_e;
endpackage

// File: rtl/mesi_dir_store.sv
module mesi_dir_store
  import mesi_dir_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  // local read port
  input  logic [IDX_W-1:0]            rd_a_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_a_tag_o,
  output mesi_e [WAYS-1:0]            rd_a_st_o,
  output logic                        rd_a_lru_o,
  // snoop read port
  input  logic [IDX_W-1:0]            rd_b_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_b_tag_o,
  output mesi_e [WAYS-1:0]            rd_b_st_o,
  output logic                        rd_b_lru_o,
  // local write port, wins over snoop on the same line
  input  logic                        loc_we_i,
  input  logic [IDX_W-1:0]            loc_idx_i,
  input  logic                        loc_way_i,
  input  logic                        loc_tag_we_i,
  input  logic [TAG_W-1:0]            loc_tag_i,
  input  mesi_e                       loc_st_i,
  input  logic                        lru_we_i,
  input  logic                        lru_i,
  // snoop write port
  input  logic                        snp_we_i,
  input  logic [IDX_W-1:0]            snp_idx_i,
  input  logic                        snp_way_i,
  input  mesi_e                       snp_st_i
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  mesi_e            st_q  [SETS][WAYS];
  logic [SETS-1:0]  lru_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic loc_sel, snp_sel;
      assign loc_sel = loc_we_i && loc_idx_i == IDX_W'(s) && loc_way_i == 1'(w);
      assign snp_sel = snp_we_i && snp_idx_i == IDX_W'(s) && snp_way_i == 1'(w);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tag_q[s][w] <= '0;
          st_q[s][w]  <= ST_I;
        end else if (loc_sel) begin
          if (loc_tag_we_i) tag_q[s][w] <= loc_tag_i;
          st_q[s][w] <= loc_st_i;
        end else if (snp_sel) begin
          st_q[s][w] <= snp_st_i;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lru_q[s] <= 1'b0;
      else if (lru_we_i && loc_idx_i == IDX_W'(s)) lru_q[s] <= lru_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_a_tag_o[w] = tag_q[rd_a_idx_i][w];
    assign rd_a_st_o[w]  = st_q[rd_a_idx_i][w];
    assign rd_b_tag_o[w] = tag_q[rd_b_idx_i][w];
    assign rd_b_st_o[w]  = st_q[rd_b_idx_i][w];
  end
  assign rd_a_lru_o = lru_q[rd_a_idx_i];
  assign rd_b_lru_o = lru_q[rd_b_idx_i];
endmodule

// File: rtl/mesi_dir_lookup.sv
module mesi_dir_lookup
  import mesi_dir_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  mesi_e [WAYS-1:0]           st_i,
  input  logic                       lru_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic                       hit_way_o,
  output mesi_e                      hit_st_o,
  output logic                       vict_way_o,
  output logic                       vict_dirty_o,
  output logic [TAG_W-1:0]           vict_tag_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (st_i[w] != ST_I) && (tags_i[w] == tag_i);
  end

  assign hit_o     = |match;
  assign hit_way_o = match[1];
  assign hit_st_o  = st_i[hit_way_o];

  // empty way first, lowest index first, else least recently used
  always_comb begin
    if (st_i[0] == ST_I)      vict_way_o = 1'b0;
    else if (st_i[1] == ST_I) vict_way_o = 1'b1;
    else                      vict_way_o = lru_i;
  end

  assign vict_dirty_o = st_i[vict_way_o] == ST_M;
  assign vict_tag_o   = tags_i[vict_way_o];
endmodule

// File: rtl/mesi_dir_ctrl.sv
module mesi_dir_ctrl
  import mesi_dir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  // lookup results for cur_addr_o
  input  logic              hit_i,
  input  logic              hit_way_i,
  input  mesi_e             hit_st_i,
  input  logic              vict_way_i,
  input  logic              vict_dirty_i,
  input  logic [TAG_W-1:0]  vict_tag_i,
  // state updates
  output logic              loc_we_o,
  output logic              loc_way_o,
  output logic              loc_tag_we_o,
  output mesi_e             loc_st_o,
  output logic              lru_we_o,
  output logic              lru_o,
  // bus handshake
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_ack_i,
  input  logic              bus_shared_i,
  // response
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_way_o,
  output logic              resp_wb_o
);
  fsm_e              state_q, state_d;
  logic [ADDR_W-1:0] addr_q, wb_addr_q;
  logic              wr_q, way_q, up_q, wb_q;
  bus_cmd_e          cmd_q;
  logic              rv_q, rh_q, rw_q, rb_q;

  logic idle, go, quick, done;

  assign idle       = state_q == FSM_IDLE;
  assign go         = idle && req_valid_i;
  assign cur_addr_o = idle ? req_addr_i : addr_q;
  // read hit, or write hit with ownership already held
  assign quick      = hit_i && (!req_write_i || hit_st_i == ST_E || hit_st_i == ST_M);
  assign done       = state_q == FSM_FILL && bus_ack_i;

  always_comb begin
    state_d      = state_q;
    loc_we_o     = 1'b0;
    loc_way_o    = hit_way_i;
    loc_tag_we_o = 1'b0;
    loc_st_o     = ST_M;
    lru_we_o     = 1'b0;
    lru_o        = ~hit_way_i;
    unique case (state_q)
      FSM_IDLE: if (go) begin
        if (quick) begin
          loc_we_o = req_write_i;
          lru_we_o = 1'b1;
        end else if (hit_i) begin
          state_d = FSM_FILL;
        end else begin
          state_d = vict_dirty_i ? FSM_WB : FSM_FILL;
        end
      end
      FSM_WB:   if (bus_ack_i) state_d = FSM_FILL;
      FSM_FILL: if (bus_ack_i) begin
        state_d      = FSM_IDLE;
        loc_we_o     = 1'b1;
        loc_way_o    = way_q;
        loc_tag_we_o = !up_q;
        loc_st_o     = wr_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        lru_we_o     = 1'b1;
        lru_o        = ~way_q;
      end
      default: state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FSM_IDLE;
      addr_q    <= '0;
      wb_addr_q <= '0;
      wr_q      <= 1'b0;
      way_q     <= 1'b0;
      up_q      <= 1'b0;
      wb_q      <= 1'b0;
      cmd_q     <= BUS_RD;
    end else begin
      state_q <= state_d;
      if (go) begin
        addr_q    <= req_addr_i;
        wr_q      <= req_write_i;
        up_q      <= hit_i;
        way_q     <= hit_i ? hit_way_i : vict_way_i;
        wb_q      <= !hit_i && vict_dirty_i;
        cmd_q     <= hit_i ? BUS_INV : (req_write_i ? BUS_RFO : BUS_RD);
        wb_addr_q <= {vict_tag_i, req_addr_i[OFF_W+IDX_W-1:OFF_W], OFF_W'(0)};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      rw_q <= 1'b0;
      rb_q <= 1'b0;
    end else begin
      rv_q <= (go && quick) || done;
      if (go && quick) begin
        rh_q <= 1'b1;
        rw_q <= hit_way_i;
        rb_q <= 1'b0;
      end else if (done) begin
        rh_q <= up_q;
        rw_q <= way_q;
        rb_q <= wb_q;
      end
    end
  end

  assign req_ready_o  = idle;
  assign bus_req_o    = !idle;
  assign bus_cmd_o    = state_q == FSM_WB ? BUS_WB : cmd_q;
  assign bus_addr_o   = state_q == FSM_WB ? wb_addr_q : {addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
  assign resp_valid_o = rv_q;
  assign resp_hit_o   = rh_q;
  assign resp_way_o   = rw_q;
  assign resp_wb_o    = rb_q;
endmodule

// File: rtl/mesi_dir.sv
module mesi_dir
  import mesi_dir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_way_o,
  output logic              resp_wb_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_ack_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_hit_o,
  output logic              snp_supply_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  loc_idx, snp_idx;
  logic [TAG_W-1:0]  loc_tag, snp_tag;

  logic [WAYS-1:0][TAG_W-1:0] a_tags, b_tags;
  mesi_e [WAYS-1:0]           a_st, b_st;
  logic                       a_lru, b_lru;

  logic             hit, hit_way, vict_way, vict_dirty;
  mesi_e            hit_st;
  logic [TAG_W-1:0] vict_tag;

  logic             s_hit, s_way, s_vway, s_vdirty;
  mesi_e            s_st, s_new;
  logic [TAG_W-1:0] s_vtag;
  logic             s_act, s_we;

  logic  loc_we, loc_way, loc_tag_we, lru_we, lru_val;
  mesi_e loc_st;

  assign loc_idx = cur_addr[OFF_W +: IDX_W];
  assign loc_tag = cur_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr_i[OFF_W +: IDX_W];
  assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  mesi_dir_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .rd_a_idx_i(loc_idx), .rd_a_tag_o(a_tags), .rd_a_st_o(a_st), .rd_a_lru_o(a_lru),
    .rd_b_idx_i(snp_idx), .rd_b_tag_o(b_tags), .rd_b_st_o(b_st), .rd_b_lru_o(b_lru),
    .loc_we_i(loc_we), .loc_idx_i(loc_idx), .loc_way_i(loc_way),
    .loc_tag_we_i(loc_tag_we), .loc_tag_i(loc_tag), .loc_st_i(loc_st),
    .lru_we_i(lru_we), .lru_i(lru_val),
    .snp_we_i(s_we), .snp_idx_i(snp_idx), .snp_way_i(s_way), .snp_st_i(s_new)
  );

  mesi_dir_lookup #(.TAG_W(TAG_W)) u_loc_lkp (
    .tags_i(a_tags), .st_i(a_st), .lru_i(a_lru), .tag_i(loc_tag),
    .hit_o(hit), .hit_way_o(hit_way), .hit_st_o(hit_st),
    .vict_way_o(vict_way), .vict_dirty_o(vict_dirty), .vict_tag_o(vict_tag)
  );

  mesi_dir_lookup #(.TAG_W(TAG_W)) u_snp_lkp (
    .tags_i(b_tags), .st_i(b_st), .lru_i(b_lru), .tag_i(snp_tag),
    .hit_o(s_hit), .hit_way_o(s_way), .hit_st_o(s_st),
    .vict_way_o(s_vway), .vict_dirty_o(s_vdirty), .vict_tag_o(s_vtag)
  );

  mesi_dir_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_ready_o,
    .cur_addr_o(cur_addr),
    .hit_i(hit), .hit_way_i(hit_way), .hit_st_i(hit_st),
    .vict_way_i(vict_way), .vict_dirty_i(vict_dirty), .vict_tag_i(vict_tag),
    .loc_we_o(loc_we), .loc_way_o(loc_way), .loc_tag_we_o(loc_tag_we), .loc_st_o(loc_st),
    .lru_we_o(lru_we), .lru_o(lru_val),
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_ack_i, .bus_shared_i,
    .resp_valid_o, .resp_hit_o, .resp_way_o, .resp_wb_o
  );

  // snoop: read downgrades to Shared, ownership or invalidate drops the line
  assign s_act        = snp_valid_i && snp_cmd_i != SNP_NONE && s_hit;
  assign s_new        = snp_cmd_i == SNP_RD ? ST_S : ST_I;
  assign s_we         = s_act && !(snp_cmd_i == SNP_RD && s_st == ST_S);
  assign snp_hit_o    = s_act;
  assign snp_supply_o = s_act && snp_cmd_i == SNP_RD && s_st == ST_M;
endmodule

// File: rtl/mesi_dir_chk.sv
module mesi_dir_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic              resp_wb_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ack_i,
  input logic [1:0]        snp_cmd_i,
  input logic              snp_hit_o,
  input logic              snp_supply_o
);
  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)); // R8

  AST_WB_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_cmd_o == 2'd0 |=>
      bus_req_o && (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2)); // R5

  AST_WB_ONLY_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_wb_o |-> !resp_hit_o); // R5

  AST_BUS_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_addr_o[OFF_W-1:0] == '0); // R2

  AST_SUPPLY_ON_READ_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_hit_o && snp_cmd_i == 2'd1); // R11

  AST_IDLE_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_req_o); // R7
endmodule

bind mesi_dir mesi_dir_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/mesi_dir_tb.sv
module mesi_dir_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_ready_o, resp_valid_o, resp_hit_o, resp_way_o, resp_wb_o;
  logic        bus_req_o;
  logic [1:0]  bus_cmd_o;
  logic [31:0] bus_addr_o;
  logic        bus_ack_i = 1'b0, bus_shared_i = 1'b0;
  logic        snp_valid_i = 1'b0;
  logic [1:0]  snp_cmd_i = '0;
  logic [31:0] snp_addr_i = '0;
  logic        snp_hit_o, snp_supply_o;

  int n_chk = 0, n_bad = 0;
  logic shared_cfg = 1'b0;

  // expected response {hit,way,wb}, expected bus {cmd,addr}
  logic [2:0]  rsp_q[$];
  string       rsp_tag[$];
  logic [33:0] bus_q[$];
  string       bus_tag[$];
  int          wait_cnt = 0;

  always #10 clk_i = ~clk_i;

  mesi_dir u_dut (.*);

  function automatic logic [31:0] la(input int tag, input int set);
    return {tag[19:0], set[3:0], 8'h00};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // response monitor
  always @(negedge clk_i) begin
    if (rst_ni && resp_valid_o) begin
      if (rsp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected response", {resp_hit_o, resp_way_o, resp_wb_o}, 0);
      end else begin
        logic [2:0] e;
        string t;
        e = rsp_q.pop_front();
        t = rsp_tag.pop_front();
        check({resp_hit_o, resp_way_o, resp_wb_o} == e, t, "resp{hit,way,wb}",
              {resp_hit_o, resp_way_o, resp_wb_o}, e);
      end
    end
  end

  // bus responder: acks one cycle after a request appears
  always @(negedge clk_i) begin
    if (bus_ack_i) begin
      bus_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (rst_ni && bus_req_o) begin
      wait_cnt++;
      if (wait_cnt == 2) begin
        if (bus_q.size() == 0) begin
          check(1'b0, "R7", "unexpected bus command", {bus_cmd_o, bus_addr_o}, 0);
        end else begin
          logic [33:0] e;
          string t;
          e = bus_q.pop_front();
          t = bus_tag.pop_front();
          check({bus_cmd_o, bus_addr_o} == e, t, "bus{cmd,addr}", {bus_cmd_o, bus_addr_o}, e);
        end
        bus_shared_i = shared_cfg;
        bus_ack_i    = 1'b1;
      end
    end
  end

  task automatic exp_bus(input logic [1:0] cmd, input logic [31:0] a, input string rq);
    bus_q.push_back({cmd, a});
    bus_tag.push_back(rq);
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input bit sh,
                        input bit hit, input bit way, input bit wb, input string rq);
    int guard;
    rsp_q.push_back({hit, way, wb});
    rsp_tag.push_back(rq);
    shared_cfg = sh;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_addr_i  = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    guard = 0;
    while (rsp_q.size() != 0 && guard < 200) begin
      @(negedge clk_i);
      guard++;
    end
    check(rsp_q.size() == 0, rq, "response pending", rsp_q.size(), 0);
    check(bus_q.size() == 0, rq, "bus commands not issued", bus_q.size(), 0);
    rsp_q.delete(); rsp_tag.delete(); bus_q.delete(); bus_tag.delete();
  endtask

  task automatic snoop(input bit v, input logic [1:0] cmd, input logic [31:0] a,
                       input bit ehit, input bit esup, input string rq);
    @(negedge clk_i);
    snp_valid_i = v;
    snp_cmd_i   = cmd;
    snp_addr_i  = a;
    #1;
    check({snp_hit_o, snp_supply_o} == {ehit, esup}, rq, "snoop{hit,supply}",
          {snp_hit_o, snp_supply_o}, {ehit, esup});
    @(negedge clk_i);
    snp_valid_i = 1'b0;
    snp_cmd_i   = '0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !resp_valid_o && !bus_req_o, "R10", "reset outputs",
          {req_ready_o, resp_valid_o, bus_req_o}, 3'b100);
    rst_ni = 1'b1;

    // R10: reset tag is zero but line is invalid
    exp_bus(2'd1, la(0, 2), "R10");
    access(0, la(0, 2), 0, 0, 0, 0, "R10");

    // R9 / R3: fill set 0 way 0 Exclusive
    exp_bus(2'd1, la(1, 0), "R9");
    access(0, la(1, 0), 0, 0, 0, 0, "R3");
    // R2: offset ignored
    access(0, la(1, 0) | 32'h3C, 0, 1, 0, 0, "R2");
    // R9: shared fill into remaining invalid way
    exp_bus(2'd1, la(2, 0), "R9");
    access(0, la(2, 0), 1, 0, 1, 0, "R3");
    // R7: write on Exclusive, no bus
    access(1, la(1, 0), 0, 1, 0, 0, "R7");
    // R8: write on Shared upgrades, aligned address
    exp_bus(2'd3, la(2, 0), "R8");
    access(1, la(2, 0) | 32'h10, 0, 1, 1, 0, "R8");
    // R4 / R5: LRU is way 0 (Modified) -> write-back then read
    exp_bus(2'd0, la(1, 0), "R5");
    exp_bus(2'd1, la(3, 0), "R5");
    access(0, la(3, 0), 0, 0, 0, 1, "R4");
    exp_bus(2'd0, la(2, 0), "R5");
    exp_bus(2'd1, la(1, 0), "R5");
    access(0, la(1, 0), 0, 0, 1, 1, "R4");
    access(0, la(1, 0), 0, 1, 1, 0, "R4");
    // R6: Exclusive victim (way 0) dropped silently
    exp_bus(2'd1, la(4, 0), "R6");
    access(0, la(4, 0), 0, 0, 0, 0, "R6");

    // R8: write miss in set 1
    exp_bus(2'd2, la(5, 1), "R8");
    access(1, la(5, 1), 0, 0, 0, 0, "R8");
    // R11: read snoop on Modified supplies, then line is Shared
    snoop(1, 2'd1, la(5, 1) | 32'h80, 1, 1, "R11");
    exp_bus(2'd3, la(5, 1), "R11");
    access(1, la(5, 1), 0, 1, 0, 0, "R11");
    // R11: read snoop on Exclusive, no supply, then line is Shared
    snoop(1, 2'd1, la(4, 0), 1, 0, "R11");
    exp_bus(2'd3, la(4, 0), "R11");
    access(1, la(4, 0), 0, 1, 0, 0, "R11");
    // R12: invalidate snoop drops line
    snoop(1, 2'd3, la(5, 1), 1, 0, "R12");
    exp_bus(2'd1, la(5, 1), "R12");
    access(0, la(5, 1), 0, 0, 0, 0, "R12");
    // R12 / R3: ownership snoop drops Modified way 0; LRU points at way 1
    snoop(1, 2'd2, la(4, 0), 1, 0, "R12");
    exp_bus(2'd1, la(6, 0), "R3");
    access(0, la(6, 0), 0, 0, 0, 0, "R3");
    // R12 / R1: miss on unrelated tag and set, and no snoop when not valid
    snoop(1, 2'd2, la(9, 3), 0, 0, "R12");
    snoop(1, 2'd2, la(7, 0), 0, 0, "R1");
    snoop(0, 2'd3, la(1, 0), 0, 0, "R12");
    access(0, la(1, 0), 0, 1, 1, 0, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule